// File: doc/BRIEF.md
# Rename Map with Buffer-Walk Recovery

This block holds the speculative mapping from architectural registers to physical tags for a single-issue out-of-order core, and keeps no separate committed copy of that mapping. When an instruction is renamed, the block records in a circular in-order buffer whether the instruction writes a register, which register it writes, the new tag it was given, and the tag that register pointed to just before. Normal retirement removes the oldest record and hands the displaced tag back to an external free pool through a one-cycle pulse.

If an exception is signalled, the block enters an undo phase. It walks the buffer from the youngest record back toward the oldest, one record per clock. It writes each record's displaced tag back into the map and returns the record's new tag to the free pool. Throughout this phase a busy flag is high and both new renames and retirements are refused. Once the buffer is empty the flag falls on the following cycle. Source operands are looked up through two combinational read ports on the map.

Top module: `rob_walk_rename`

## Requirements
- R1: After reset every architectural register r maps to tag r, the buffer is empty (cmt_ready low), busy is low, ren_ready is high and free_valid is low.
- R2: A rename is taken on a cycle where ren_valid and ren_ready are both high; if ren_has_dst is 1, the lookup ports show ren_tag for ren_dst from the next cycle on, and the record keeps the tag ren_dst held before.
- R3: ren_ready is low whenever the buffer holds DEPTH records, busy is high, or exc_valid is high.
- R4: A retirement happens on a cycle where cmt_valid and cmt_ready are both high and removes the oldest record; on the next cycle free_valid is 1 with free_tag equal to that record's displaced tag, if the record writes a register.
- R5: cmt_ready is low whenever the buffer is empty, busy is high, or exc_valid is high; a refused retirement produces no free_valid pulse.
- R6: exc_valid seen while busy is low takes no rename or retirement in that cycle, and busy is high from the next cycle.
- R7: On each busy cycle with records left, the youngest remaining record's displaced tag is written back to its register, and free_valid pulses on the next cycle with that record's new tag, so tags come back youngest first.
- R8: During the undo phase a record that writes no register takes one cycle, changes no mapping and gives no free_valid pulse.
- R9: When a busy cycle finds the buffer empty, busy is low on the next cycle; a walk over N records keeps busy high for N+1 cycles.
- R10: While busy is high, ren_ready and cmt_ready are low and exc_valid has no effect.
- R11: src_a_tag and src_b_tag show, without a clock edge, the current mapping of src_a and src_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request |
| ren_has_dst | input | 1 | The instruction writes a register |
| ren_dst | input | 3 | Destination architectural register |
| ren_tag | input | 5 | Freshly allocated physical tag |
| ren_ready | output | 1 | Rename can be taken this cycle |
| src_a | input | 3 | First source register lookup |
| src_a_tag | output | 5 | Current tag of src_a |
| src_b | input | 3 | Second source register lookup |
| src_b_tag | output | 5 | Current tag of src_b |
| cmt_valid | input | 1 | Retire the oldest record |
| cmt_ready | output | 1 | Retirement can be taken this cycle |
| exc_valid | input | 1 | Start the undo walk |
| busy | output | 1 | Undo walk in progress |
| free_valid | output | 1 | A tag is being released |
| free_tag | output | 5 | The released tag |

## Verification
A wrong tail pointer or a lost record shows during the next undo walk. The busy flag stays high for the wrong number of cycles, and freed tags come back in an order that does not match the youngest-first sequence of earlier renames. A wrong displaced tag shows at the lookup ports one cycle after the step that restores it, and on free_tag one cycle after the retirement that releases it. A wrong head pointer or wrong occupancy count shows on the next retirement as a wrong free_tag, and on cmt_ready or ren_ready when the buffer drains or fills.

// File: rtl/rwr_pkg.sv
package rwr_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DEF_DEPTH = 16;
    localparam int DEF_ARCH  = 8;
    localparam int DEF_TAGS  = 32;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_UNDO = 1'b1
    } walk_state_e;

    function automatic int ptr_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/rwr_map.sv
module rwr_map #(
    parameter int NUM_ARCH = rwr_pkg::DEF_ARCH,
    parameter int NUM_TAGS = rwr_pkg::DEF_TAGS,
    localparam int AW = rwr_pkg::ptr_bits(NUM_ARCH),
    localparam int TW = rwr_pkg::ptr_bits(NUM_TAGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_a_idx,
    output logic [TW-1:0] rd_a_tag,
    input  logic [AW-1:0] rd_b_idx,
    output logic [TW-1:0] rd_b_tag,
    input  logic [AW-1:0] rd_c_idx,
    output logic [TW-1:0] rd_c_tag,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [TW-1:0] tag_q [NUM_ARCH];

    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[g] <= TW'(g);
            end else if (wr_en && (wr_idx == AW'(g))) begin
                tag_q[g] <= wr_tag;
            end
        end
    end

    assign rd_a_tag = tag_q[rd_a_idx];
    assign rd_b_tag = tag_q[rd_b_idx];
    assign rd_c_tag = tag_q[rd_c_idx];

    // R2 / R7: a write addresses an existing register
    assert_wr_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_ARCH));
endmodule

// File: rtl/rwr_rob.sv
module rwr_rob #(
    parameter int DEPTH = rwr_pkg::DEF_DEPTH,
    parameter int AW    = 3,
    parameter int TW    = 5,
    localparam int PW   = rwr_pkg::ptr_bits(DEPTH),
    localparam int CW   = rwr_pkg::ptr_bits(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          push_dv,
    input  logic [AW-1:0] push_dst,
    input  logic [TW-1:0] push_new,
    input  logic [TW-1:0] push_old,
    input  logic          pop_head,
    input  logic          pop_tail,
    output logic          head_dv,
    output logic [TW-1:0] head_old,
    output logic          young_dv,
    output logic [AW-1:0] young_dst,
    output logic [TW-1:0] young_new,
    output logic [TW-1:0] young_old,
    output logic          full,
    output logic          empty
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic          dv;
        logic [AW-1:0] dst;
        logic [TW-1:0] new_tag;
        logic [TW-1:0] old_tag;
    } rec_t;

    rec_t          rec_q [DEPTH];
    logic [PW-1:0] head_q, tail_q, young_idx;
    logic [CW-1:0] cnt_q;
    rec_t          head_rec, young_rec;

    function automatic logic [PW-1:0] step_fwd(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] step_back(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            rec_q[tail_q] <= '{dv: push_dv, dst: push_dst, new_tag: push_new, old_tag: push_old};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                tail_q <= step_fwd(tail_q);
            end else if (pop_tail) begin
                tail_q <= step_back(tail_q);
            end
            if (pop_head) begin
                head_q <= step_fwd(head_q);
            end
            cnt_q <= cnt_q + CW'(push) - CW'(pop_head) - CW'(pop_tail);
        end
    end

    assign young_idx = step_back(tail_q);
    assign head_rec  = rec_q[head_q];
    assign young_rec = rec_q[young_idx];
    assign head_dv   = head_rec.dv;
    assign head_old  = head_rec.old_tag;
    assign young_dv  = young_rec.dv;
    assign young_dst = young_rec.dst;
    assign young_new = young_rec.new_tag;
    assign young_old = young_rec.old_tag;
    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < CW'(DEPTH)));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (pop_head || pop_tail) |-> (cnt_q != '0));

    assert_undo_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        pop_tail |-> (!push && !pop_head));

    assert_undo_shrinks_R7: assert property (@(posedge clk) disable iff (rst)
        pop_tail |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/rwr_ctrl.sv
module rwr_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ren_valid,
    input  logic cmt_valid,
    input  logic exc_valid,
    input  logic full,
    input  logic empty,
    output logic busy,
    output logic ren_ready,
    output logic cmt_ready,
    output logic ren_fire,
    output logic cmt_fire,
    output logic walk_step
);
    timeunit 1ns;
    timeprecision 100ps;
    import rwr_pkg::*;

    walk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (exc_valid) state_d = ST_UNDO;
            ST_UNDO: if (empty)     state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    assign busy      = (state_q == ST_UNDO);
    assign ren_ready = !busy && !exc_valid && !full;
    assign cmt_ready = !busy && !exc_valid && !empty;
    assign ren_fire  = ren_valid && ren_ready;
    assign cmt_fire  = cmt_valid && cmt_ready;
    assign walk_step = busy && !empty;

    assert_busy_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && exc_valid) |=> busy);

    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && empty) |=> !busy);
endmodule

// File: rtl/rob_walk_rename.sv
module rob_walk_rename #(
    parameter int DEPTH    = rwr_pkg::DEF_DEPTH,
    parameter int NUM_ARCH = rwr_pkg::DEF_ARCH,
    parameter int NUM_TAGS = rwr_pkg::DEF_TAGS,
    localparam int AW = rwr_pkg::ptr_bits(NUM_ARCH),
    localparam int TW = rwr_pkg::ptr_bits(NUM_TAGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ren_valid,
    input  logic          ren_has_dst,
    input  logic [AW-1:0] ren_dst,
    input  logic [TW-1:0] ren_tag,
    output logic          ren_ready,
    input  logic [AW-1:0] src_a,
    output logic [TW-1:0] src_a_tag,
    input  logic [AW-1:0] src_b,
    output logic [TW-1:0] src_b_tag,
    input  logic          cmt_valid,
    output logic          cmt_ready,
    input  logic          exc_valid,
    output logic          busy,
    output logic          free_valid,
    output logic [TW-1:0] free_tag
);
    timeunit 1ns;
    timeprecision 100ps;

    logic          ren_fire, cmt_fire, walk_step;
    logic          full, empty;
    logic          head_dv, young_dv;
    logic [TW-1:0] head_old, young_new, young_old, prior_tag;
    logic [AW-1:0] young_dst;
    logic          map_we;
    logic [AW-1:0] map_widx;
    logic [TW-1:0] map_wtag;

    rwr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ren_valid (ren_valid),
        .cmt_valid (cmt_valid),
        .exc_valid (exc_valid),
        .full      (full),
        .empty     (empty),
        .busy      (busy),
        .ren_ready (ren_ready),
        .cmt_ready (cmt_ready),
        .ren_fire  (ren_fire),
        .cmt_fire  (cmt_fire),
        .walk_step (walk_step)
    );

    // One map write port, shared: the walk and renames never overlap.
    always_comb begin
        if (walk_step) begin
            map_we   = young_dv;
            map_widx = young_dst;
            map_wtag = young_old;
        end else begin
            map_we   = ren_fire && ren_has_dst;
            map_widx = ren_dst;
            map_wtag = ren_tag;
        end
    end

    rwr_map #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_TAGS (NUM_TAGS)
    ) u_map (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (src_a),
        .rd_a_tag (src_a_tag),
        .rd_b_idx (src_b),
        .rd_b_tag (src_b_tag),
        .rd_c_idx (ren_dst),
        .rd_c_tag (prior_tag),
        .wr_en    (map_we),
        .wr_idx   (map_widx),
        .wr_tag   (map_wtag)
    );

    rwr_rob #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .TW    (TW)
    ) u_rob (
        .clk       (clk),
        .rst       (rst),
        .push      (ren_fire),
        .push_dv   (ren_has_dst),
        .push_dst  (ren_dst),
        .push_new  (ren_tag),
        .push_old  (prior_tag),
        .pop_head  (cmt_fire),
        .pop_tail  (walk_step),
        .head_dv   (head_dv),
        .head_old  (head_old),
        .young_dv  (young_dv),
        .young_dst (young_dst),
        .young_new (young_new),
        .young_old (young_old),
        .full      (full),
        .empty     (empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            free_valid <= 1'b0;
            free_tag   <= '0;
        end else if (walk_step) begin
            free_valid <= young_dv;
            free_tag   <= young_new;
        end else if (cmt_fire) begin
            free_valid <= head_dv;
            free_tag   <= head_old;
        end else begin
            free_valid <= 1'b0;
        end
    end

    // R4 / R7: a release always follows a retirement or an undo step
    assert_free_cause_R4: assert property (@(posedge clk) disable iff (rst)
        free_valid |-> $past(cmt_fire || walk_step));
endmodule

// File: tb/rob_walk_rename_tb.sv
module rob_walk_rename_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ren_valid = 1'b0, ren_has_dst = 1'b0;
    logic [2:0] ren_dst = '0;
    logic [4:0] ren_tag = '0;
    logic       ren_ready;
    logic [2:0] src_a = '0, src_b = '0;
    logic [4:0] src_a_tag, src_b_tag;
    logic       cmt_valid = 1'b0, cmt_ready;
    logic       exc_valid = 1'b0, busy;
    logic       free_valid;
    logic [4:0] free_tag;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    int m_map [8];
    int q_dv [16], q_dst [16], q_new [16], q_old [16];
    int m_head = 0, m_tail = 0, m_cnt = 0;
    bit m_busy = 1'b0;

    always #2.5 clk = ~clk;

    rob_walk_rename u_dut (
        .clk (clk), .rst (rst),
        .ren_valid (ren_valid), .ren_has_dst (ren_has_dst), .ren_dst (ren_dst),
        .ren_tag (ren_tag), .ren_ready (ren_ready),
        .src_a (src_a), .src_a_tag (src_a_tag), .src_b (src_b), .src_b_tag (src_b_tag),
        .cmt_valid (cmt_valid), .cmt_ready (cmt_ready),
        .exc_valid (exc_valid), .busy (busy),
        .free_valid (free_valid), .free_tag (free_tag)
    );

    // op[1] retire, op[0] rename, then has_dst, dst, tag
    localparam logic [10:0] VEC [12] = '{
        {2'd1, 1'b1, 3'd2, 5'd8},
        {2'd1, 1'b1, 3'd5, 5'd9},
        {2'd1, 1'b0, 3'd0, 5'd0},
        {2'd1, 1'b1, 3'd2, 5'd10},
        {2'd3, 1'b1, 3'd7, 5'd11},
        {2'd2, 1'b0, 3'd0, 5'd0},
        {2'd2, 1'b0, 3'd0, 5'd0},
        {2'd1, 1'b1, 3'd3, 5'd12},
        {2'd1, 1'b1, 3'd5, 5'd13},
        {2'd1, 1'b0, 3'd4, 5'd3},
        {2'd1, 1'b1, 3'd3, 5'd14},
        {2'd3, 1'b1, 3'd1, 5'd15}
    };

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    task automatic check_map(input string rq);
        for (int a = 0; a < 8; a++) begin
            src_a = 3'(a);
            src_b = 3'(7 - a);
            #1;
            chk(rq, "lookup a", int'(src_a_tag), m_map[a]);
            chk(rq, "lookup b", int'(src_b_tag), m_map[7 - a]);
        end
    endtask

    task automatic tick(input bit rv, input bit hd, input int dst, input int tag,
                        input bit cv, input bit ev, input string rq);
        int probe;
        bit e_rr, e_cr, ef_v;
        int ef_t;
        string rq_rdy;
        @(negedge clk);
        ren_valid = rv; ren_has_dst = hd; ren_dst = 3'(dst); ren_tag = 5'(tag);
        cmt_valid = cv; exc_valid = ev;
        probe = (m_busy && m_cnt > 0) ? q_dst[(m_tail + 15) % 16] : dst;
        src_a = 3'(probe);
        src_b = 3'(probe ^ 1);
        #1;
        e_rr = !m_busy && !ev && (m_cnt < 16);
        e_cr = !m_busy && !ev && (m_cnt > 0);
        rq_rdy = m_busy ? "R10" : (ev ? "R6" : "R3");
        chk(rq_rdy, "ren_ready", int'(ren_ready), int'(e_rr));
        rq_rdy = m_busy ? "R10" : (ev ? "R6" : "R5");
        chk(rq_rdy, "cmt_ready", int'(cmt_ready), int'(e_cr));
        ef_v = 1'b0; ef_t = 0;
        if (m_busy) begin
            if (m_cnt == 0) begin
                m_busy = 1'b0;
            end else begin
                m_tail = (m_tail + 15) % 16;
                m_cnt--;
                if (q_dv[m_tail] != 0) begin
                    m_map[q_dst[m_tail]] = q_old[m_tail];
                    ef_v = 1'b1; ef_t = q_new[m_tail];
                end
            end
        end else if (ev) begin
            m_busy = 1'b1;
        end else begin
            if (cv && e_cr) begin
                if (q_dv[m_head] != 0) begin ef_v = 1'b1; ef_t = q_old[m_head]; end
                m_head = (m_head + 1) % 16;
                m_cnt--;
            end
            if (rv && e_rr) begin
                q_dv[m_tail] = int'(hd); q_dst[m_tail] = dst; q_new[m_tail] = tag;
                q_old[m_tail] = m_map[dst];
                if (hd) m_map[dst] = tag;
                m_tail = (m_tail + 1) % 16;
                m_cnt++;
            end
        end
        @(posedge clk);
        #1;
        chk(rq, "busy", int'(busy), int'(m_busy));
        chk(rq, "free_valid", int'(free_valid), int'(ef_v));
        if (ef_v) chk(rq, "free_tag", int'(free_tag), ef_t);
        chk(rq, "map after edge a", int'(src_a_tag), m_map[probe]);
        chk(rq, "map after edge b", int'(src_b_tag), m_map[probe ^ 1]);
        ren_valid = 1'b0; cmt_valid = 1'b0; exc_valid = 1'b0;
    endtask

    task automatic run_walk(input int n);
        int cyc = 0;
        string rq;
        tick(1'b1, 1'b1, 4, 30, 1'b1, 1'b1, "R6");
        for (int i = 0; i < 40 && busy; i++) begin
            if (m_cnt == 0) rq = "R9";
            else if (q_dv[(m_tail + 15) % 16] == 0) rq = "R8";
            else rq = "R7";
            tick(1'b1, 1'b1, 6, 29, 1'b1, 1'b1, rq);
            cyc++;
        end
        chk("R9", "busy cycles", cyc, n + 1);
        check_map("R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog run did not finish");
            report();
        end
    end

    initial begin
        for (int a = 0; a < 8; a++) m_map[a] = a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "ren_ready", int'(ren_ready), 1);
        chk("R1", "cmt_ready", int'(cmt_ready), 0);
        chk("R1", "free_valid", int'(free_valid), 0);
        check_map("R1");
        check_map("R11");

        for (int v = 0; v < 12; v++) begin
            tick(VEC[v][9], VEC[v][8], int'(VEC[v][7:5]), int'(VEC[v][4:0]),
                 VEC[v][10], 1'b0, (VEC[v][10] ? "R4" : "R2"));
        end
        check_map("R2");

        run_walk(6);

        for (int i = 0; i < 16; i++) tick(1'b1, 1'b1, i % 8, 16 + i, 1'b0, 1'b0, "R2");
        tick(1'b1, 1'b1, 0, 31, 1'b0, 1'b0, "R3");
        chk("R3", "ren_ready when full", int'(ren_ready), 0);
        run_walk(16);

        tick(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, "R5");
        run_walk(0);
        check_map("R11");

        finished = 1'b1;
        report();
    end
endmodule